// File: doc/BRIEF.md
# Programmable Memory Region Decoder

This block maps each physical address of a 1 GB space (30-bit addresses) to the region or bank that should serve it. Eleven regions can be placed anywhere: four DRAM banks, four local-bus banks and three PCI memory/I/O windows. Each of them has its own base, a power-of-two size and an enable bit. Two more regions are fixed. The on-chip register space always occupies the top megabyte of the space. The boot flash always starts at address zero, and only its size can be set.

A request presents an address with a valid strobe. One clock later the block returns a one-hot select, the data width of the local-bus bank that was chosen, and a decode error when no region claims the address. Software loads the region descriptors through a single write port, one 32-bit word per region. The block does not model DRAM, flash or PCI cycle timing.

Top module: `mem_region_decoder`

## Requirements
- R1: After reset, every programmable region is disabled and the flash size is 64 KB (2^16). All outputs (sel_valid, sel_onehot, sel_lb_width, dec_err) read zero.
- R2: Addresses 0x3FF00000 to 0x3FFFFFFF always select the register region, select bit 0. This region takes priority over all other regions.
- R3: The flash region starts at address 0 and selects bit 1. Its size is 2^n bytes, where n is taken from wdata[20:16] of a write to cfg_idx 11. n is clamped to the range 16 to 30.
- R4: Programmable region i (cfg_idx i, 0-3 DRAM, 4-7 local bus, 8-10 PCI) selects bit i+2 when it is enabled and addr[29:n] equals base[29:n]. The base is {wdata[13:0], 16'h0000}, n is wdata[20:16] clamped to the range 16 to 30, and base bits below n are ignored.
- R5: A region whose enable bit (wdata[31]) was last written as 0 never matches.
- R6: For a DRAM bank (cfg_idx 0-3), n is clamped to the range 22 to 26 (4 MB to 64 MB).
- R7: At most one select bit is set. The fixed regions win over the programmable regions. Among programmable regions, the lowest index wins.
- R8: On a local-bus hit, sel_lb_width returns the bank's width code from wdata[25:24] (0 = 8-bit, 1 = 16-bit, 2 = 32-bit; code 3 is stored as 2). On any other result sel_lb_width is 0.
- R9: An address that no region claims raises dec_err together with sel_valid for exactly one cycle, with sel_onehot equal to zero.
- R10: Results appear on the clock edge after the request. Without a request, sel_valid and dec_err are 0 and sel_onehot is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_idx | input | 4 | Descriptor index (0-10 regions, 11 flash size) |
| cfg_wdata | input | 32 | Descriptor word |
| req_valid | input | 1 | Address request strobe |
| req_addr | input | 30 | Request address |
| sel_valid | output | 1 | Result valid, one cycle after the request |
| sel_onehot | output | 13 | One-hot select (0 register space, 1 flash, 2+i region i) |
| sel_lb_width | output | 2 | Local-bus width code of the selected bank |
| dec_err | output | 1 | Address is unmapped |

## Verification
The hardest cases to reach from the ports are overlaps, where several regions claim the same address and only the priority order decides which one is selected. To create them, the bench first places a PCI window over two local-bus banks. It then enables a second PCI window that spans the whole space, underneath the fixed register and flash regions. Addresses are then chosen that fall into each layer of this stack. The size clamps are checked by writing sizes outside the allowed range and probing an address that hits only if the clamped size was applied.

// File: rtl/mrd_pkg.sv
package mrd_pkg;
  localparam int ADDR_W   = 30;
  localparam int GRAN_W   = 16;
  localparam int BASE_W   = ADDR_W - GRAN_W;
  localparam int SZ_W     = 5;
  localparam int N_DRAM   = 4;
  localparam int N_LB     = 4;
  localparam int N_PCI    = 3;
  localparam int N_PROG   = N_DRAM + N_LB + N_PCI;
  localparam int N_FIXED  = 2;
  localparam int N_SEL    = N_PROG + N_FIXED;
  localparam int IDX_W    = 4;
  localparam int FLASH_IDX = N_PROG;
  localparam int REG_SZ   = 20;
  localparam logic [ADDR_W-1:0] REG_BASE = 30'h3FF0_0000;
  localparam int SZ_MIN   = GRAN_W;
  localparam int SZ_MAX   = ADDR_W;
  localparam int DRAM_SZ_MIN = 22;
  localparam int DRAM_SZ_MAX = 26;

  typedef struct packed {
    logic              en;
    logic [1:0]        width;
    logic [SZ_W-1:0]   sz;
    logic [BASE_W-1:0] base;
  } region_cfg_t;

  function automatic logic [SZ_W-1:0] clamp_sz(logic [SZ_W-1:0] v, int lo, int hi);
    if (int'(v) < lo)      return SZ_W'(lo);
    else if (int'(v) > hi) return SZ_W'(hi);
    else                   return v;
  endfunction

  function automatic logic [ADDR_W-1:0] size_mask(logic [SZ_W-1:0] sz);
    logic [ADDR_W-1:0] m;
    for (int i = 0; i < ADDR_W; i++) m[i] = (i >= int'(sz));
    return m;
  endfunction
endpackage

// File: rtl/mrd_cfg_regs.sv
module mrd_cfg_regs
  import mrd_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_we,
  input  logic [IDX_W-1:0]             cfg_idx,
  input  logic [31:0]                  cfg_wdata,
  output region_cfg_t [N_PROG-1:0]     regions,
  output logic [SZ_W-1:0]              flash_sz
);
  region_cfg_t [N_PROG-1:0] regions_d;
  logic [N_PROG-1:0]        reg_en;
  logic [SZ_W-1:0]          flash_sz_d;
  logic                     flash_en;
  logic [SZ_W-1:0]          raw_sz;
  logic [1:0]               raw_w;

  assign raw_sz = cfg_wdata[20:16];
  assign raw_w  = (cfg_wdata[25:24] == 2'd3) ? 2'd2 : cfg_wdata[25:24];

  for (genvar i = 0; i < N_PROG; i++) begin : g_reg
    assign reg_en[i] = cfg_we && (cfg_idx == IDX_W'(i));
    always_comb begin
      regions_d[i].en    = cfg_wdata[31];
      regions_d[i].width = (i >= N_DRAM && i < N_DRAM + N_LB) ? raw_w : 2'd0;
      regions_d[i].base  = cfg_wdata[BASE_W-1:0];
      if (i < N_DRAM) regions_d[i].sz = clamp_sz(raw_sz, DRAM_SZ_MIN, DRAM_SZ_MAX);
      else            regions_d[i].sz = clamp_sz(raw_sz, SZ_MIN, SZ_MAX);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         regions[i] <= '0;
      else if (reg_en[i]) regions[i] <= regions_d[i];
    end
  end

  assign flash_en   = cfg_we && (cfg_idx == IDX_W'(FLASH_IDX));
  assign flash_sz_d = clamp_sz(raw_sz, SZ_MIN, SZ_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flash_sz <= SZ_W'(SZ_MIN);
    else if (flash_en) flash_sz <= flash_sz_d;
  end

  // R6
  dram_sz_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !regions[0].en || (int'(regions[0].sz) >= DRAM_SZ_MIN && int'(regions[0].sz) <= DRAM_SZ_MAX));
  // R3
  flash_sz_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(flash_sz) >= SZ_MIN && int'(flash_sz) <= SZ_MAX);
endmodule

// File: rtl/mrd_match.sv
module mrd_match
  import mrd_pkg::*;
(
  input  logic [ADDR_W-1:0]        addr,
  input  region_cfg_t [N_PROG-1:0] regions,
  input  logic [SZ_W-1:0]          flash_sz,
  output logic                     reg_hit,
  output logic                     flash_hit,
  output logic [N_PROG-1:0]        prog_hit
);
  localparam logic [ADDR_W-1:0] REG_MASK = ~((ADDR_W'(1) << REG_SZ) - ADDR_W'(1));

  assign reg_hit   = ((addr ^ REG_BASE) & REG_MASK) == '0;
  assign flash_hit = (addr & size_mask(flash_sz)) == '0;

  for (genvar i = 0; i < N_PROG; i++) begin : g_cmp
    logic [ADDR_W-1:0] base_full;
    assign base_full   = {regions[i].base, {GRAN_W{1'b0}}};
    assign prog_hit[i] = regions[i].en &&
                         (((addr ^ base_full) & size_mask(regions[i].sz)) == '0);
  end
endmodule

// File: rtl/mrd_prio.sv
module mrd_prio
  import mrd_pkg::*;
(
  input  logic                      reg_hit,
  input  logic                      flash_hit,
  input  logic [N_PROG-1:0]         prog_hit,
  input  region_cfg_t [N_PROG-1:0]  regions,
  output logic [N_SEL-1:0]          sel,
  output logic [1:0]                width,
  output logic                      miss
);
  always_comb begin
    logic found;
    sel   = '0;
    width = 2'd0;
    found = 1'b0;
    if (reg_hit) begin
      sel[0] = 1'b1;
      found  = 1'b1;
    end else if (flash_hit) begin
      sel[1] = 1'b1;
      found  = 1'b1;
    end
    for (int i = 0; i < N_PROG; i++) begin
      if (prog_hit[i] && !found) begin
        sel[i+N_FIXED] = 1'b1;
        width          = regions[i].width;
        found          = 1'b1;
      end
    end
    miss = !found;
  end
endmodule

// File: rtl/mem_region_decoder.sv
module mem_region_decoder
  import mrd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_idx,
  input  logic [31:0]       cfg_wdata,
  input  logic              req_valid,
  input  logic [29:0]       req_addr,
  output logic              sel_valid,
  output logic [12:0]       sel_onehot,
  output logic [1:0]        sel_lb_width,
  output logic              dec_err
);
  logic [1:0]               rst_sync;
  logic                     rst_int_n;
  region_cfg_t [N_PROG-1:0] regions;
  logic [SZ_W-1:0]          flash_sz;
  logic                     reg_hit, flash_hit, miss;
  logic [N_PROG-1:0]        prog_hit;
  logic [N_SEL-1:0]         sel_d;
  logic [1:0]               width_d;
  logic                     valid_d, err_d;
  logic [N_SEL-1:0]         sel_gated;
  logic [1:0]               width_gated;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  mrd_cfg_regs u_cfg (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cfg_we   (cfg_we),
    .cfg_idx  (cfg_idx),
    .cfg_wdata(cfg_wdata),
    .regions  (regions),
    .flash_sz (flash_sz)
  );

  mrd_match u_match (
    .addr     (req_addr),
    .regions  (regions),
    .flash_sz (flash_sz),
    .reg_hit  (reg_hit),
    .flash_hit(flash_hit),
    .prog_hit (prog_hit)
  );

  mrd_prio u_prio (
    .reg_hit  (reg_hit),
    .flash_hit(flash_hit),
    .prog_hit (prog_hit),
    .regions  (regions),
    .sel      (sel_d),
    .width    (width_d),
    .miss     (miss)
  );

  always_comb begin
    valid_d     = req_valid;
    err_d       = req_valid && miss;
    sel_gated   = req_valid ? sel_d : '0;
    width_gated = req_valid ? width_d : 2'd0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      sel_valid    <= 1'b0;
      sel_onehot   <= '0;
      sel_lb_width <= 2'd0;
      dec_err      <= 1'b0;
    end else begin
      sel_valid    <= valid_d;
      sel_onehot   <= sel_gated;
      sel_lb_width <= width_gated;
      dec_err      <= err_d;
    end
  end

  // R7
  onehot_sel_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0(sel_onehot));
  // R9
  err_no_sel_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    dec_err |-> (sel_valid && sel_onehot == '0));
  // R9
  hit_or_err_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    sel_valid |-> ($countones(sel_onehot) == (dec_err ? 0 : 1)));
  // R10
  req_latency_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    req_valid |=> sel_valid);
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !req_valid |=> (!sel_valid && !dec_err && sel_onehot == '0));
  // R2
  reg_space_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (req_valid && req_addr[29:20] == 10'h3FF) |=> sel_onehot[0]);
  // R8
  width_lb_only_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (sel_lb_width != 2'd0) |-> (sel_onehot[N_FIXED+N_DRAM +: N_LB] != '0));
endmodule

// File: tb/mem_region_decoder_tb.sv
module mem_region_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [29:0] req_addr = '0;
  logic        sel_valid;
  logic [12:0] sel_onehot;
  logic [1:0]  sel_lb_width;
  logic        dec_err;

  int tests = 0;
  int fails = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  bit          done = 1'b0;

  always #2 clk = ~clk;

  mem_region_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_addr(req_addr),
    .sel_valid(sel_valid), .sel_onehot(sel_onehot),
    .sel_lb_width(sel_lb_width), .dec_err(dec_err)
  );

  function automatic logic [31:0] mk(logic [13:0] b, logic [4:0] sz, logic [1:0] w, logic en);
    return {en, 5'b0, w, 3'b0, sz, 2'b0, b};
  endfunction

  task automatic wr(input logic [3:0] idx, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b0;
    cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send(input logic [29:0] a, input int bit_i, input logic [1:0] w, input string tag);
    logic [12:0] oh;
    @(negedge clk);
    oh = (bit_i < 0) ? 13'd0 : (13'd1 << bit_i);
    req_valid = 1'b1; req_addr = a;
    exp_q.push_back({(bit_i < 0), w, oh});
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  always begin
    @(posedge clk);
    #1;
    if (rst_n && !done) begin
      if (sel_valid) begin
        logic [15:0] e;
        string t;
        tests++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R10: result without request got %h expected none", sel_onehot);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if ({dec_err, sel_lb_width, sel_onehot} !== e) begin
            fails++;
            $display("FAIL %s: got err=%0b w=%0d sel=%h expected err=%0b w=%0d sel=%h",
                     t, dec_err, sel_lb_width, sel_onehot, e[15], e[14:13], e[12:0]);
          end
        end
      end else if (dec_err || sel_onehot != '0) begin
        tests++; fails++;
        $display("FAIL R10: idle output err=%0b sel=%h expected 0 0", dec_err, sel_onehot);
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        fails++;
        $display("FAIL watchdog: run hung, got %0d cycles expected under 20000", cyc);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    tests++;
    if (sel_valid || dec_err || sel_onehot != '0 || sel_lb_width != '0) begin
      fails++;
      $display("FAIL R1: outputs after reset got v=%0b e=%0b sel=%h expected all zero",
               sel_valid, dec_err, sel_onehot);
    end
    // R1/R3: reset flash is 64 KB, programmable regions off
    send(30'h0000_0100, 1, 2'd0, "R1");
    send(30'h0001_0000, -1, 2'd0, "R1");
    idle(2);
    // R2 register space
    send(30'h3FF0_0010, 0, 2'd0, "R2");
    send(30'h3FFF_FFFF, 0, 2'd0, "R2");
    idle(1);
    // R3 flash size programming and clamping
    wr(4'd11, mk(14'd0, 5'd20, 2'd0, 1'b0));
    send(30'h0008_0000, 1, 2'd0, "R3");
    send(30'h0010_0000, -1, 2'd0, "R3");
    idle(1);
    wr(4'd11, mk(14'd0, 5'd5, 2'd0, 1'b0));
    send(30'h0001_0000, -1, 2'd0, "R3");
    send(30'h0000_FFFF, 1, 2'd0, "R3");
    idle(1);
    // R4 DRAM0 16 MB at 0x01000000; DRAM3 with unaligned base bits
    wr(4'd0, mk(14'h0100, 5'd24, 2'd0, 1'b1));
    wr(4'd3, mk(14'h0413, 5'd24, 2'd0, 1'b1));
    send(30'h01AB_CDEF, 2, 2'd0, "R4");
    send(30'h0200_0000, -1, 2'd0, "R4");
    send(30'h0400_0000, 5, 2'd0, "R4");
    idle(1);
    // R6 clamps: 28 -> 26, 20 -> 22
    wr(4'd1, mk(14'h0800, 5'd28, 2'd0, 1'b1));
    wr(4'd2, mk(14'h1000, 5'd20, 2'd0, 1'b1));
    send(30'h0BFF_FFFC, 3, 2'd0, "R6");
    send(30'h0C00_0000, -1, 2'd0, "R6");
    send(30'h1030_0000, 4, 2'd0, "R6");
    send(30'h1040_0000, -1, 2'd0, "R6");
    idle(1);
    // R5 disabled bank
    wr(4'd0, mk(14'h0100, 5'd24, 2'd0, 1'b0));
    send(30'h01AB_CDEF, -1, 2'd0, "R5");
    idle(1);
    // R8 local-bus widths
    wr(4'd4, mk(14'h2000, 5'd20, 2'd1, 1'b1));
    wr(4'd5, mk(14'h2010, 5'd20, 2'd3, 1'b1));
    send(30'h2000_0004, 6, 2'd1, "R8");
    send(30'h2010_0004, 7, 2'd2, "R8");
    send(30'h0BFF_FFFC, 3, 2'd0, "R8");
    idle(1);
    // R7 overlapping programmable regions
    wr(4'd8, mk(14'h2000, 5'd24, 2'd0, 1'b1));
    send(30'h2000_0004, 6, 2'd1, "R7");
    send(30'h2080_0000, 10, 2'd0, "R7");
    // R9 unmapped while others exist
    send(30'h3F00_0000, -1, 2'd0, "R9");
    idle(1);
    // R7 fixed regions over whole-space window
    wr(4'd9, mk(14'h0000, 5'd30, 2'd0, 1'b1));
    send(30'h3FF0_0000, 0, 2'd0, "R7");
    send(30'h0000_0100, 1, 2'd0, "R7");
    send(30'h3000_0000, 11, 2'd0, "R7");
    send(30'h1030_0000, 4, 2'd0, "R7");
    idle(4);
    tests++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R10: results missing got %0d pending expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule